// File: doc/BRIEF.md
# Masked Vector Register Execution Unit

This block is a small integer vector unit that sits beside a scalar host. It holds a file of general-purpose vector registers, and all of its arithmetic runs between those registers, with the scalar input port as the only other operand source. The host issues one vector instruction at a time. The unit then walks the elements in index order, one element per clock cycle.

Six instruction classes share a single sequencer:
- register copy;
- element-wise add of two vectors;
- add of a broadcast scalar to every element;
- sum reduction to a scalar;
- dot product to a scalar;
- a move gated by a mask register.

Element results go back into a destination vector register. The two reductions return a 32-bit scalar on a result port.

A narrow host element port lets the host place data into the file one element at a time and read any element back combinationally. This port stands in for the memory traffic that is outside this block.

Top module: `vecRegUnit`

## Requirements
- R1: After reset, busy, done and scalarOut are 0, and every element of every vector register reads 0.
- R2: A host element write (hostWrEn high while busy is low) stores hostWrData into element hostWrIdx of register hostWrReg at the next clock edge. hostRdData always shows element hostRdIdx of register hostRdReg combinationally. A host write while busy is high has no effect.
- R3: The opcode encodings are 0 copy, 1 vector add, 2 scalar add, 3 sum, 4 dot and 5 masked move.
  - An instruction is accepted when issueValid is high, busy is low and the opcode is one of these codes.
  - busy is then high for exactly 16 cycles, starting in the cycle after acceptance.
  - done is a single-cycle pulse in the first cycle after busy falls.
- R4: While busy is high, issueValid is ignored. Opcodes 6 and 7 are never accepted: busy stays low and no state changes.
- R5: Copy (0) writes element i of register srcASel into element i of register dstSel, for every i.
- R6: Vector add (1) writes srcA[i] + srcB[i] modulo 2^16 into dst[i].
- R7: Scalar add (2) writes srcA[i] + scalarIn modulo 2^16 into dst[i]. scalarIn is captured in the cycle of acceptance.
- R8: Sum (3) sets scalarOut to the 32-bit wrapped sum of the sign-extended elements of srcA. The new value is present when done is high and is held until the next reduction completes.
- R9: Dot (4) sets scalarOut to the 32-bit wrapped sum of the signed products srcA[i]*srcB[i]. Its timing follows R8.
- R10: Masked move (5) writes srcA[i] into dst[i] only where bit 0 of element i of register maskSel is 1. Other destination elements keep their value.
- R11: Copy, vector add, scalar add and masked move leave scalarOut unchanged. Sum and dot leave every vector register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Instruction issue request |
| opCode | input | 3 | Instruction code |
| dstSel | input | 3 | Destination register |
| srcASel | input | 3 | First source register |
| srcBSel | input | 3 | Second source register |
| maskSel | input | 3 | Mask register |
| scalarIn | input | 16 | Scalar operand for the scalar add |
| hostWrEn | input | 1 | Host element write strobe |
| hostWrReg | input | 3 | Host write register |
| hostWrIdx | input | 4 | Host write element index |
| hostWrData | input | 16 | Host write data |
| hostRdReg | input | 3 | Host read register |
| hostRdIdx | input | 4 | Host read element index |
| hostRdData | output | 16 | Host read data |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Completion pulse |
| scalarOut | output | 32 | Reduction result |

## Verification
The assertions assume that the host drives issueValid and opCode as stable levels sampled at the clock edge. They also assume that the register selects of an accepted instruction are captured at acceptance, so later changes on those selects have no effect during a run.

The stimulus issues each instruction from the falling edge and waits for done before the next issue. It deliberately raises issueValid, hostWrEn and the invalid opcodes during a run or while idle, to check that they are ignored. Random opcodes and register selects include aliasing between destination, sources and mask, and directed cases push the sums and products across their wrap points.

// File: rtl/vecPkg.sv
package vecPkg;
  typedef enum logic [2:0] {
    OP_COPY = 3'd0,
    OP_VADD = 3'd1,
    OP_SADD = 3'd2,
    OP_SUM  = 3'd3,
    OP_DOT  = 3'd4,
    OP_MMOV = 3'd5
  } opT;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic start;  // instruction accepted this edge
    logic step;   // one element handled this edge
    logic last;   // the element handled is the final one
    opT   op;     // instruction in flight
  } strobeT;

  function automatic logic isReduce(opT op);
    return (op == OP_SUM) || (op == OP_DOT);
  endfunction
endpackage

// File: rtl/vecCtrl.sv
module vecCtrl
  import vecPkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int VLEN     = 16,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int IDX_W   = $clog2(VLEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic [2:0]       opCode,
  input  logic [REG_W-1:0] dstSel,
  input  logic [REG_W-1:0] srcASel,
  input  logic [REG_W-1:0] srcBSel,
  input  logic [REG_W-1:0] maskSel,
  output strobeT           strobe,
  output logic [IDX_W-1:0] idx,
  output logic [REG_W-1:0] dstR,
  output logic [REG_W-1:0] srcAR,
  output logic [REG_W-1:0] srcBR,
  output logic [REG_W-1:0] maskR,
  output logic             busy,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(VLEN - 1);

  opT   opR;
  logic opKnown;
  logic accept;

  assign opKnown = (opCode <= 3'd5);
  assign accept  = issueValid && !busy && opKnown;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      idx   <= '0;
      opR   <= OP_COPY;
      dstR  <= '0;
      srcAR <= '0;
      srcBR <= '0;
      maskR <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        idx   <= '0;
        opR   <= opT'(opCode);
        dstR  <= dstSel;
        srcAR <= srcASel;
        srcBR <= srcBSel;
        maskR <= maskSel;
      end else if (busy) begin
        idx <= idx + 1'b1;
        if (idx == LAST_IDX) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.start = accept;
    strobe.step  = busy;
    strobe.last  = busy && (idx == LAST_IDX);
    strobe.op    = opR;
  end

  p_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> busy && (idx == '0));
  p_run_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && idx == LAST_IDX) |=> (!busy && done));
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_hold_instr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && issueValid) |=> ($stable(opR) && $stable(dstR) && $stable(srcAR)));
  p_bad_op_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && issueValid && opCode > 3'd5) |=> !busy);
endmodule

// File: rtl/vecDatapath.sv
module vecDatapath
  import vecPkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int VLEN     = 16,
  parameter int ELEM_W   = 16,
  parameter int ACC_W    = 32,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int IDX_W   = $clog2(VLEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [IDX_W-1:0]  idx,
  input  logic [REG_W-1:0]  dstR,
  input  logic [REG_W-1:0]  srcAR,
  input  logic [REG_W-1:0]  srcBR,
  input  logic [REG_W-1:0]  maskR,
  input  logic              busy,
  input  logic [ELEM_W-1:0] scalarIn,
  input  logic              hostWrEn,
  input  logic [REG_W-1:0]  hostWrReg,
  input  logic [IDX_W-1:0]  hostWrIdx,
  input  logic [ELEM_W-1:0] hostWrData,
  input  logic [REG_W-1:0]  hostRdReg,
  input  logic [IDX_W-1:0]  hostRdIdx,
  output logic [ELEM_W-1:0] hostRdData,
  output logic [ACC_W-1:0]  scalarOut
);
  localparam int EXT_W = ACC_W - ELEM_W;

  logic [ELEM_W-1:0] rf [NUM_REGS][VLEN];
  logic [ELEM_W-1:0] scalarR;
  logic [ACC_W-1:0]  acc;

  logic [ELEM_W-1:0] aElem, bElem, dstOld;
  logic              maskBit;
  logic              exeWr;
  logic [ELEM_W-1:0] exeVal;
  logic [ACC_W-1:0]  aExt, bExt, term;
  logic              hostWr;

  assign aElem   = rf[srcAR][idx];
  assign bElem   = rf[srcBR][idx];
  assign dstOld  = rf[dstR][idx];
  assign maskBit = rf[maskR][idx][0];
  assign aExt    = {{EXT_W{aElem[ELEM_W-1]}}, aElem};
  assign bExt    = {{EXT_W{bElem[ELEM_W-1]}}, bElem};
  assign hostWr  = hostWrEn && !busy;
  assign hostRdData = rf[hostRdReg][hostRdIdx];

  always_comb begin
    exeWr  = 1'b0;
    exeVal = aElem;
    term   = aExt;
    case (strobe.op)
      OP_COPY: exeWr = strobe.step;
      OP_VADD: begin exeWr = strobe.step; exeVal = aElem + bElem; end
      OP_SADD: begin exeWr = strobe.step; exeVal = aElem + scalarR; end
      OP_MMOV: exeWr = strobe.step && maskBit;
      OP_DOT:  term = aExt * bExt;
      default: term = aExt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++)
        for (int e = 0; e < VLEN; e++)
          rf[r][e] <= '0;
    end else if (exeWr) begin
      rf[dstR][idx] <= exeVal;
    end else if (hostWr) begin
      rf[hostWrReg][hostWrIdx] <= hostWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scalarR   <= '0;
      acc       <= '0;
      scalarOut <= '0;
    end else begin
      if (strobe.start) begin
        scalarR <= scalarIn;
        acc     <= '0;
      end else if (strobe.step && isReduce(strobe.op)) begin
        acc <= acc + term;
        if (strobe.last) scalarOut <= acc + term;
      end
    end
  end

  p_mask_keep_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && strobe.op == OP_MMOV && !maskBit)
      |=> rf[$past(dstR)][$past(idx)] == $past(dstOld));
  p_scalar_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !isReduce(strobe.op)) |=> $stable(scalarOut));
  p_reduce_no_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && isReduce(strobe.op)) |=> rf[$past(dstR)][$past(idx)] == $past(dstOld));
endmodule

// File: rtl/vecRegUnit.sv
module vecRegUnit
  import vecPkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int VLEN     = 16,
  parameter int ELEM_W   = 16,
  parameter int ACC_W    = 32,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int IDX_W   = $clog2(VLEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [2:0]        opCode,
  input  logic [REG_W-1:0]  dstSel,
  input  logic [REG_W-1:0]  srcASel,
  input  logic [REG_W-1:0]  srcBSel,
  input  logic [REG_W-1:0]  maskSel,
  input  logic [ELEM_W-1:0] scalarIn,
  input  logic              hostWrEn,
  input  logic [REG_W-1:0]  hostWrReg,
  input  logic [IDX_W-1:0]  hostWrIdx,
  input  logic [ELEM_W-1:0] hostWrData,
  input  logic [REG_W-1:0]  hostRdReg,
  input  logic [IDX_W-1:0]  hostRdIdx,
  output logic [ELEM_W-1:0] hostRdData,
  output logic              busy,
  output logic              done,
  output logic [ACC_W-1:0]  scalarOut
);
  strobeT           strobe;
  logic [IDX_W-1:0] idx;
  logic [REG_W-1:0] dstR, srcAR, srcBR, maskR;

  vecCtrl #(.NUM_REGS(NUM_REGS), .VLEN(VLEN)) uCtrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .opCode(opCode),
    .dstSel(dstSel), .srcASel(srcASel), .srcBSel(srcBSel), .maskSel(maskSel),
    .strobe(strobe), .idx(idx), .dstR(dstR), .srcAR(srcAR), .srcBR(srcBR),
    .maskR(maskR), .busy(busy), .done(done)
  );

  vecDatapath #(.NUM_REGS(NUM_REGS), .VLEN(VLEN), .ELEM_W(ELEM_W), .ACC_W(ACC_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .idx(idx), .dstR(dstR),
    .srcAR(srcAR), .srcBR(srcBR), .maskR(maskR), .busy(busy), .scalarIn(scalarIn),
    .hostWrEn(hostWrEn), .hostWrReg(hostWrReg), .hostWrIdx(hostWrIdx),
    .hostWrData(hostWrData), .hostRdReg(hostRdReg), .hostRdIdx(hostRdIdx),
    .hostRdData(hostRdData), .scalarOut(scalarOut)
  );
endmodule

// File: tb/sim_vecRegUnit.sv
`timescale 1ns/1ps
module sim_vecRegUnit;
  localparam int NR = 8;
  localparam int VL = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, issueValid, hostWrEn, busy, done;
  logic [2:0] opCode, dstSel, srcASel, srcBSel, maskSel, hostWrReg, hostRdReg;
  logic [3:0] hostWrIdx, hostRdIdx;
  logic [15:0] scalarIn, hostWrData, hostRdData;
  logic [31:0] scalarOut;

  vecRegUnit u0 (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .opCode(opCode),
    .dstSel(dstSel), .srcASel(srcASel), .srcBSel(srcBSel), .maskSel(maskSel),
    .scalarIn(scalarIn), .hostWrEn(hostWrEn), .hostWrReg(hostWrReg),
    .hostWrIdx(hostWrIdx), .hostWrData(hostWrData), .hostRdReg(hostRdReg),
    .hostRdIdx(hostRdIdx), .hostRdData(hostRdData), .busy(busy), .done(done),
    .scalarOut(scalarOut)
  );

  int tests = 0;
  int fails = 0;
  logic [15:0] mdl [NR][VL];
  logic [31:0] expScalar = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model of one instruction, element order 0..VL-1
  function automatic void refExec(int op, int d, int a, int b, int m, logic [15:0] s);
    int acc = 0;
    for (int i = 0; i < VL; i++) begin
      int pa = int'($signed(mdl[a][i]));
      int pb = int'($signed(mdl[b][i]));
      case (op)
        0: mdl[d][i] = mdl[a][i];
        1: mdl[d][i] = mdl[a][i] + mdl[b][i];
        2: mdl[d][i] = mdl[a][i] + s;
        3: acc = acc + pa;
        4: acc = acc + pa * pb;
        5: if (mdl[m][i][0]) mdl[d][i] = mdl[a][i];
        default: ;
      endcase
    end
    if (op == 3 || op == 4) expScalar = 32'(acc);
  endfunction

  task automatic compareRegs(string req);
    int bad = 0;
    for (int r = 0; r < NR; r++)
      for (int e = 0; e < VL; e++) begin
        hostRdReg = 3'(r); hostRdIdx = 4'(e); #1;
        if (hostRdData !== mdl[r][e]) begin
          if (bad == 0)
            $display("FAIL %s reg%0d[%0d] actual=%0h expected=%0h", req, r, e, hostRdData, mdl[r][e]);
          bad++;
        end
      end
    chk(req, 32'(bad), 32'd0);
  endtask

  task automatic hostWrite(int r, int e, logic [15:0] v);
    @(negedge clk);
    hostWrEn = 1'b1; hostWrReg = 3'(r); hostWrIdx = 4'(e); hostWrData = v;
    @(negedge clk);
    hostWrEn = 1'b0;
    mdl[r][e] = v;
  endtask

  task automatic drive(int op, int d, int a, int b, int m, logic [15:0] s);
    opCode = 3'(op); dstSel = 3'(d); srcASel = 3'(a);
    srcBSel = 3'(b); maskSel = 3'(m); scalarIn = s;
  endtask

  task automatic waitDone(output int cnt);
    cnt = busy ? 1 : 0;
    while (!done) begin
      @(negedge clk);
      if (busy) cnt++;
    end
  endtask

  task automatic runInstr(int op, int d, int a, int b, int m, logic [15:0] s, string req);
    int cnt;
    @(negedge clk);
    drive(op, d, a, b, m, s);
    issueValid = 1'b1;
    @(negedge clk);
    issueValid = 1'b0;
    drive(7, 0, 0, 0, 0, 16'hDEAD);
    waitDone(cnt);
    chk("R3 busy length", 32'(cnt), 32'd16);
    refExec(op, d, a, b, m, s);
    compareRegs(req);
    chk({req, " / R11 scalar"}, scalarOut, expScalar);
    @(negedge clk);
    chk("R3 done pulse", {31'd0, done}, 32'd0);
  endtask

  function automatic string tagOf(int op);
    case (op)
      0: return "R5 copy";
      1: return "R6 vadd";
      2: return "R7 sadd";
      3: return "R8 sum";
      4: return "R9 dot";
      default: return "R10 mmove";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seedVal;
    int cnt;
    seedVal = $urandom(32'd2024);
    rstN = 1'b0; issueValid = 1'b0; hostWrEn = 1'b0;
    hostWrReg = '0; hostWrIdx = '0; hostWrData = '0; hostRdReg = '0; hostRdIdx = '0;
    drive(0, 0, 0, 0, 0, 16'h0);
    for (int r = 0; r < NR; r++) for (int e = 0; e < VL; e++) mdl[r][e] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 scalarOut", scalarOut, 32'd0);
    compareRegs("R1 regs");

    // R2 host write and read back
    hostWrite(3, 7, 16'hBEEF);
    compareRegs("R2 host write");

    // directed: wrap cases
    for (int e = 0; e < VL; e++) begin
      hostWrite(1, e, 16'hFFFF);
      hostWrite(2, e, 16'h8000);
      hostWrite(4, e, (e % 2 == 0) ? 16'h0001 : 16'h0002);
    end
    runInstr(1, 5, 1, 4, 0, 16'h0, "R6 vadd wrap");
    runInstr(2, 6, 1, 0, 0, 16'h0003, "R7 sadd wrap");
    runInstr(4, 0, 2, 2, 0, 16'h0, "R9 dot wrap");
    runInstr(3, 0, 1, 0, 0, 16'h0, "R8 sum negative");
    runInstr(0, 7, 4, 0, 0, 16'h0, "R5 copy / R11 scalar held");
    runInstr(5, 3, 1, 0, 4, 16'h0, "R10 mask alternating");
    runInstr(5, 3, 2, 0, 2, 16'h0, "R10 mask all zero");
    runInstr(5, 3, 2, 0, 1, 16'h0, "R10 mask all ones");

    // R4 invalid opcode ignored
    @(negedge clk);
    drive(6, 0, 1, 1, 1, 16'h1);
    issueValid = 1'b1;
    @(negedge clk);
    issueValid = 1'b0;
    chk("R4 opcode 6 ignored", {31'd0, busy}, 32'd0);
    compareRegs("R4 opcode 6 no change");

    // R4 / R2: issue and host write while busy are ignored
    @(negedge clk);
    drive(2, 5, 4, 0, 0, 16'h0010);
    issueValid = 1'b1;
    @(negedge clk);
    drive(1, 6, 1, 1, 0, 16'h0);
    hostWrEn = 1'b1; hostWrReg = 3'd0; hostWrIdx = 4'd0; hostWrData = 16'h1234;
    repeat (3) @(negedge clk);
    issueValid = 1'b0; hostWrEn = 1'b0;
    waitDone(cnt);
    refExec(2, 5, 4, 0, 0, 16'h0010);
    compareRegs("R4 R2 ignored while busy");
    @(negedge clk);
    chk("R4 no second run", {31'd0, busy}, 32'd0);

    // random fill and random instructions
    for (int r = 0; r < NR; r++)
      for (int e = 0; e < VL; e++)
        hostWrite(r, e, 16'($urandom));
    for (int n = 0; n < 60; n++) begin
      int op = $urandom_range(0, 5);
      runInstr(op, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
               $urandom_range(0, 7), 16'($urandom), tagOf(op));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule